// File: doc/BRIEF.md
# Single-Channel Aligned PWM Generator with Shadowed Duty

This block produces one pulse-width modulated output from an 8-bit counter that advances on an external channel-clock tick. Software programs a period, a duty value and a polarity bit through a small register write/read port, then sets an enable bit. A mode bit picks left-aligned output, where the counter runs up and wraps, or center-aligned output, where it runs up to the period and back down again.

A duty value written while the channel runs goes into a shadow register. It reaches the comparator only when the counter returns to zero, so the output never shows a period built from two different duty values. A wait input, gated by a halt-in-wait control bit, can freeze the counter. Two duty encodings have fixed meanings: a duty at or above the period keeps the output at its active level, and the all-ones duty keeps it at its inactive level.

Top module: `pwm_chan`

## Requirements
- R1: After reset every register reads zero, the channel is disabled in left-aligned mode, and `pwm_o` is 1, the inverse of the zero polarity.
- R2: Register map on `addr_i`: 0 = control (bit0 enable, bit1 polarity, bit2 center mode, bit3 halt-in-wait, upper bits read zero), 1 = period, 2 = duty. A write takes effect at the clock edge where `wr_en_i` is high. `rdata_o` shows the addressed register combinationally, and for duty it shows the last value written even when that value is still pending.
- R3: While disabled the counter is held at zero and `pwm_o` equals the inverse of polarity. A duty written while disabled is active at the first tick after enable.
- R4: Left-aligned mode: each effective tick moves the counter from 0 up to the period and then wraps it to 0. The output is at the polarity level while counter <= duty. For duty < period, the output is high for duty+1 of every period+1 ticks with polarity 1, and for period-duty ticks with polarity 0.
- R5: Center-aligned mode with period >= 1: the counter runs up from 0 to the period and back down, so one output cycle is 2*period ticks. For duty < period, the output is high for 2*duty ticks of that cycle with polarity 1, and for 2*(period-duty) ticks with polarity 0.
- R6: A duty value that is at or above the period, other than all ones, holds the output at the polarity level for the whole cycle in both modes.
- R7: A duty value of all ones holds the output at the inverse of polarity while the channel is enabled.
- R8: A duty write made while the channel is enabled changes the output only after the counter next returns to zero.
- R9: With halt-in-wait set, asserting `wait_i` freezes the counter and the output. With halt-in-wait clear, `wait_i` has no effect.
- R10: The counter moves only at clock edges where `tick_i` is high. It holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| tick_i | input | 1 | Channel-clock enable tick |
| wait_i | input | 1 | Wait-mode indication |
| pwm_o | output | 1 | PWM output level |

## Verification
The bench sweeps every small period in both alignments and both polarities, across every duty below, at and above the period, plus the all-ones code. It counts high ticks over one exact cycle and compares the count with the arithmetic formula. An off-by-one in the compare shows up as a count one too high or one too low. A wrong turn-around point in center mode doubles or drops the slot at the peak. Mixing up the two special duty codes inverts a constant output. Directed steps with a hand-driven tick check three more failures: a design without the shadow register switches to the new duty in the middle of a cycle, a design that ignores halt-in-wait keeps counting during wait, and a design that ignores the bit being clear stalls during wait.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PER  = 2'd1,
    REG_DUTY = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;

  // bit order matches the control register layout, msb first
  typedef struct packed {
    logic halt_wait;
    logic center;
    logic pol;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         roll_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] per_o,
  output logic [W-1:0] duty_buf_o,
  output logic [W-1:0] duty_act_o,
  output logic [W-1:0] rdata_o
);
  localparam int unsigned PAD_W = W - CTRL_W;

  ctrl_t        ctrl_q;
  logic [W-1:0] per_q, buf_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= '0;
      buf_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_CTRL: ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        REG_PER:  per_q  <= wdata_i;
        REG_DUTY: buf_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  // shadow transfer: continuous while idle, at counter return while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               act_q <= '0;
    else if (!ctrl_q.en || roll_i) act_q <= buf_q;
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      REG_PER:  rdata_o = per_q;
      REG_DUTY: rdata_o = buf_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign per_o      = per_q;
  assign duty_buf_o = buf_q;
  assign duty_act_o = act_q;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         run_i,
  input  logic         center_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         roll_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic [W:0]   cnt_inc;
  logic         per_zero, at_top_l, peak_c, floor_c;

  assign cnt_inc  = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign per_zero = (per_i == '0);
  assign at_top_l = (cnt_q >= per_i);
  assign peak_c   = (cnt_inc >= {1'b0, per_i});
  assign floor_c  = (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (run_i) begin
      if (!center_i) begin
        cnt_q <= at_top_l ? '0 : cnt_q + ONE;
        up_q  <= 1'b1;
      end else if (per_zero) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else if (up_q) begin
        if (peak_c) begin
          cnt_q <= per_i;
          up_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else if (floor_c) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign roll_o = run_i & (center_i ? (per_zero | (~up_q & floor_c)) : at_top_l);
  assign cnt_o  = cnt_q;
  assign up_o   = up_q;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic         pol_i,
  input  logic         center_i,
  input  logic         up_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o
);
  logic active;

  always_comb begin
    if (duty_i == '1)          active = 1'b0;
    else if (duty_i >= per_i)  active = 1'b1;
    else if (center_i && up_i) active = (cnt_i < duty_i);
    else                       active = (cnt_i <= duty_i);
  end

  assign pwm_o = (en_i & active) ? pol_i : ~pol_i;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              wait_i,
  output logic              pwm_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] per, duty_buf, duty_act, cnt;
  logic              up, roll, run;
  logic              en_w, pol_w, center_w, halt_w;

  assign en_w     = ctrl.en;
  assign pol_w    = ctrl.pol;
  assign center_w = ctrl.center;
  assign halt_w   = ctrl.halt_wait;
  assign run      = en_w & tick_i & ~(halt_w & wait_i);

  pwm_regs #(.W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .roll_i     (roll),
    .ctrl_o     (ctrl),
    .per_o      (per),
    .duty_buf_o (duty_buf),
    .duty_act_o (duty_act),
    .rdata_o    (rdata_o)
  );

  pwm_counter #(.W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .run_i    (run),
    .center_i (center_w),
    .per_i    (per),
    .cnt_o    (cnt),
    .up_o     (up),
    .roll_o   (roll)
  );

  pwm_compare #(.W(DATA_W)) u_cmp (
    .en_i     (en_w),
    .pol_i    (pol_w),
    .center_i (center_w),
    .up_i     (up),
    .cnt_i    (cnt),
    .per_i    (per),
    .duty_i   (duty_act),
    .pwm_o    (pwm_o)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
  import pwm_chan_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic         tick_i,
  input logic         wait_i,
  input logic         pwm_o,
  input logic         en,
  input logic         pol,
  input logic         halt,
  input logic [W-1:0] cnt,
  input logic         up,
  input logic         roll,
  input logic [W-1:0] duty_buf,
  input logic [W-1:0] duty_act
);
  // R3
  idle_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> pwm_o == !pol);
  // R3
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> cnt == '0);
  // R9
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && halt && wait_i && !wr_en_i) |=> ($stable(cnt) && $stable(up)));
  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !tick_i && !wr_en_i) |=> $stable(cnt));
  // R8
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !roll) |=> $stable(duty_act));
  // R7
  all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && duty_act == '1) |-> pwm_o == !pol);
  // R2
  duty_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DUTY) |=> duty_buf == $past(wdata_i));
endmodule

bind pwm_chan pwm_chan_chk #(.W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .tick_i   (tick_i),
  .wait_i   (wait_i),
  .pwm_o    (pwm_o),
  .en       (en_w),
  .pol      (pol_w),
  .halt     (halt_w),
  .cnt      (cnt),
  .up       (up),
  .roll     (roll),
  .duty_buf (duty_buf),
  .duty_act (duty_act)
);

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic       wt = 1'b0;
  logic       pwm;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwm_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .wait_i(wt), .pwm_o(pwm)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm", int'(pwm), 1);
    for (int a = 0; a < 3; a++) begin
      addr = 2'(a);
      #0.5;
      check("R1 rdata", int'(rdata), 0);
    end

    // R2 readback
    wr(2'd0, 8'hFE); addr = 2'd0; #0.5; check("R2 ctrl", int'(rdata), 8'h0E);
    wr(2'd1, 8'h5A); addr = 2'd1; #0.5; check("R2 per", int'(rdata), 8'h5A);
    wr(2'd0, 8'h02);
    // R3 disabled output is inverse polarity
    check("R3 idle pol1", int'(pwm), 0);

    // R4 R5 R6 R7 sweep
    tick = 1'b1;
    for (int c = 0; c < 2; c++)
      for (int p = 0; p <= 12; p++)
        for (int di = 0; di <= 15; di++)
          for (int pl = 0; pl < 2; pl++) begin
            int d, n, hi, exp;
            string tag;
            if (c == 1 && p == 0) continue;
            d = (di == 15) ? 255 : di;
            n = (c == 1) ? 2 * p : p + 1;
            wr(2'd0, 8'h00);
            wr(2'd1, 8'(p));
            wr(2'd2, 8'(d));
            wr(2'd0, 8'(1 | (pl << 1) | (c << 2)));
            hi = 0;
            for (int k = 0; k < n; k++) begin
              hi += int'(pwm);
              @(negedge clk);
            end
            if (d == 255) begin exp = (pl == 1) ? 0 : n; tag = "R7"; end
            else if (d >= p) begin exp = (pl == 1) ? n : 0; tag = "R6"; end
            else if (c == 0) begin exp = (pl == 1) ? d + 1 : p - d; tag = "R4"; end
            else begin exp = (pl == 1) ? 2 * d : 2 * (p - d); tag = "R5"; end
            check(tag, hi, exp);
          end
    tick = 1'b0;

    // R8 shadowed duty
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd9);
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h03);
    pulse(2);
    wr(2'd2, 8'd7);
    addr = 2'd2; #0.5;
    check("R2 pending duty read", int'(rdata), 7);
    pulse(3);
    check("R8 old duty kept", int'(pwm), 0);
    // R10 no tick, no motion
    repeat (4) @(negedge clk);
    check("R10 hold", int'(pwm), 0);
    pulse(5);
    pulse(5);
    check("R8 new duty after wrap", int'(pwm), 1);

    // R9 halt in wait
    wr(2'd0, 8'h00);
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h0B);
    pulse(3);
    check("R9 at compare", int'(pwm), 1);
    wt = 1'b1;
    pulse(3);
    check("R9 frozen", int'(pwm), 1);
    wr(2'd0, 8'h03);
    pulse(1);
    check("R9 wait ignored", int'(pwm), 0);
    wt = 1'b0;

    // R3 disable and duty applies on enable
    wr(2'd0, 8'h02);
    check("R3 idle", int'(pwm), 0);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h03);
    check("R3 enable cnt0", int'(pwm), 1);
    pulse(1);
    check("R3 new duty", int'(pwm), 0);

    summary();
  end
endmodule